// File: doc/BRIEF.md
# Byte-Loaded 12-Bit DAC Code Register

This block is the digital front end of a 12-bit converter that is fed from an 8-bit bus. A 12-bit right-justified code is assembled in two partial writes: a low part that holds eight bits and a high part that holds four bits. Each part has its own active-low select, and both parts share the 8-bit bus and one active-low write strobe. A second register stage, the DAC stage, drives the code output. An active-low load strobe controls the DAC stage. Because that strobe is independent of the write strobe, several instances can share one load line and change their outputs together.

All control inputs are asynchronous to the block. They pass through a synchronizer that is SYNC_STAGES flops deep, and the bus is delayed by the same amount so that data stays aligned with its strobes. While a part's select and the write are both low, the part follows the bus. The part then holds its value from the first of the two signals to return high.

The DAC stage follows the combined word while its load is low and holds when the load goes high. A static configuration input selects automatic transfer. In that mode the high-part select also acts as the load, so a low write followed by a high write updates the output.

Top module: `dac_byte_loader`

## Requirements
- R1: While reset is asserted and immediately after reset, code_o is 0.
- R2: While lo_sel_n_i and wr_n_i are both low, the low part loads bus_i[7:0]. This part forms code bits 7..0.
- R3: While hi_sel_n_i and wr_n_i are both low, the high part loads bus_i[3:0]. This part forms code bits 11..8. Bus bits 7..4 are ignored.
- R4: A part keeps the bus value it saw before the first of its select or the write returned high. Later bus changes do not affect it, even if the other strobe stays low.
- R5: The two parts may be written in either order, and the resulting code is the same.
- R6: With auto_xfer_i low, code_o follows the combined word while ld_n_i is low. code_o holds while ld_n_i is high, so writes alone do not change it.
- R7: With auto_xfer_i high, the high-part select acts as the load and ld_n_i is ignored. A low write followed by a high write puts the new 12-bit code on code_o.
- R8: When both selects are high, or the write is high, no part changes, whatever the bus does.
- R9: A strobe change made between clock edges shows on code_o after exactly SYNC_STAGES+1 rising edges, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_xfer_i | input | 1 | Static mode: 1 = high-part select also loads the DAC stage |
| lo_sel_n_i | input | 1 | Active-low select of the low 8-bit part |
| hi_sel_n_i | input | 1 | Active-low select of the high 4-bit part |
| wr_n_i | input | 1 | Active-low write strobe shared by both parts |
| ld_n_i | input | 1 | Active-low DAC-stage load strobe |
| bus_i | input | 8 | Shared data bus |
| code_o | output | 12 | Current DAC code |

## Verification
The assertions assume that auto_xfer_i changes only while all strobes are idle. They also assume that a bus value meant for capture is stable for the full synchronizer window in which its select and write are low. The stimulus changes the mode only between operations, with every strobe high and time to settle. It holds each strobe for four clocks and changes the bus only at the same half-cycle as a strobe's rising edge, or later. Because the bus and the strobes share the same delay, the edge that locks a part never sees the new bus value.

// File: rtl/dbl_pkg.sv
package dbl_pkg;
   // synchronized control bundle, all active low
   typedef struct packed {
      logic lo_sel_n;
      logic hi_sel_n;
      logic wr_n;
      logic ld_n;
   } dbl_ctl_t;

   localparam int unsigned CTL_W = $bits(dbl_ctl_t);
   localparam dbl_ctl_t CTL_IDLE = '{lo_sel_n: 1'b1, hi_sel_n: 1'b1, wr_n: 1'b1, ld_n: 1'b1};
endpackage

// File: rtl/dbl_sync.sv
module dbl_sync #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 1) begin : g_bad
         $error("dbl_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [W-1:0] pipe_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) pipe_q[i] <= RST_VAL;
      end else begin
         pipe_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
      end
   end

   assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/dbl_section.sv
module dbl_section #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o,
   output logic [W-1:0] nxt_o
);
   generate
      if (W < 1) begin : g_bad
         $error("dbl_section: W must be at least 1");
      end
   endgenerate

   // value the part will hold after this edge; feeds a transparent DAC stage
   assign nxt_o = en_i ? d_i : q_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= nxt_o;
   end
endmodule

// File: rtl/dbl_dac_stage.sv
module dbl_dac_stage #(
   parameter int unsigned CODE_W   = 12,
   parameter bit          AUTO_OPT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              auto_i,
   input  logic              hi_sel_n_s,
   input  logic              ld_n_s,
   input  logic [CODE_W-1:0] word_nxt_i,
   output logic              ld_act_o,
   output logic [CODE_W-1:0] code_o
);
   generate
      if (AUTO_OPT) begin : g_auto
         assign ld_act_o = auto_i ? !hi_sel_n_s : !ld_n_s;
      end else begin : g_manual
         logic unused_auto;
         assign unused_auto = auto_i ^ hi_sel_n_s;
         assign ld_act_o = !ld_n_s;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        code_o <= '0;
      else if (ld_act_o) code_o <= word_nxt_i;
   end
endmodule

// File: rtl/dac_byte_loader.sv
module dac_byte_loader #(
   parameter int unsigned BUS_W       = 8,
   parameter int unsigned CODE_W      = 12,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          AUTO_OPT    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              auto_xfer_i,
   input  logic              lo_sel_n_i,
   input  logic              hi_sel_n_i,
   input  logic              wr_n_i,
   input  logic              ld_n_i,
   input  logic [BUS_W-1:0]  bus_i,
   output logic [CODE_W-1:0] code_o
);
   import dbl_pkg::*;

   localparam int unsigned HI_W = CODE_W - BUS_W;

   generate
      if (CODE_W <= BUS_W || HI_W > BUS_W) begin : g_bad_w
         $error("dac_byte_loader: need BUS_W < CODE_W <= 2*BUS_W");
      end
      if (SYNC_STAGES < 1) begin : g_bad_s
         $error("dac_byte_loader: SYNC_STAGES must be at least 1");
      end
   endgenerate

   dbl_ctl_t          ctl_raw, ctl_s;
   logic [BUS_W-1:0]  bus_s;
   logic              lo_en, hi_en, ld_act;
   logic [BUS_W-1:0]  lo_q, lo_nxt;
   logic [HI_W-1:0]   hi_q, hi_nxt;

   assign ctl_raw = '{lo_sel_n: lo_sel_n_i, hi_sel_n: hi_sel_n_i,
                      wr_n: wr_n_i, ld_n: ld_n_i};

   dbl_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
      .clk(clk), .rst_n(rst_n), .d_i(ctl_raw), .q_o(ctl_s));

   // bus delayed as far as the strobes, so the locking edge sees old data
   dbl_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_dly (
      .clk(clk), .rst_n(rst_n), .d_i(bus_i), .q_o(bus_s));

   assign lo_en = !ctl_s.lo_sel_n && !ctl_s.wr_n;
   assign hi_en = !ctl_s.hi_sel_n && !ctl_s.wr_n;

   dbl_section #(.W(BUS_W)) u_lo (
      .clk(clk), .rst_n(rst_n), .en_i(lo_en), .d_i(bus_s),
      .q_o(lo_q), .nxt_o(lo_nxt));

   dbl_section #(.W(HI_W)) u_hi (
      .clk(clk), .rst_n(rst_n), .en_i(hi_en), .d_i(bus_s[HI_W-1:0]),
      .q_o(hi_q), .nxt_o(hi_nxt));

   dbl_dac_stage #(.CODE_W(CODE_W), .AUTO_OPT(AUTO_OPT)) u_dac (
      .clk(clk), .rst_n(rst_n), .auto_i(auto_xfer_i),
      .hi_sel_n_s(ctl_s.hi_sel_n), .ld_n_s(ctl_s.ld_n),
      .word_nxt_i({hi_nxt, lo_nxt}), .ld_act_o(ld_act), .code_o(code_o));
endmodule

// File: rtl/dac_byte_loader_chk.sv
module dac_byte_loader_chk #(
   parameter int unsigned BUS_W  = 8,
   parameter int unsigned CODE_W = 12,
   localparam int unsigned HI_W  = CODE_W - BUS_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              auto_xfer_i,
   input logic              lo_en,
   input logic              hi_en,
   input logic              ld_act,
   input logic [BUS_W-1:0]  bus_s,
   input logic [BUS_W-1:0]  lo_q,
   input logic [HI_W-1:0]   hi_q,
   input logic [CODE_W-1:0] code_o
);
   always @(negedge clk) begin
      if (!rst_n) AST_RESET_ZERO: assert (code_o == '0); // R1
   end

   AST_LO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      lo_en |=> lo_q == $past(bus_s)); // R2
   AST_HI_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      hi_en |=> hi_q == $past(bus_s[HI_W-1:0])); // R3
   AST_LO_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !lo_en |=> $stable(lo_q)); // R4
   AST_HI_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !hi_en |=> $stable(hi_q)); // R8
   AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_act |=> $stable(code_o)); // R6
   AST_DAC_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_act && !lo_en && !hi_en) |=> code_o == $past({hi_q, lo_q})); // R6
   AST_AUTO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_xfer_i && hi_en) |=> code_o[CODE_W-1:BUS_W] == $past(bus_s[HI_W-1:0])); // R7
endmodule

bind dac_byte_loader dac_byte_loader_chk #(.BUS_W(BUS_W), .CODE_W(CODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .auto_xfer_i(auto_xfer_i), .lo_en(lo_en),
   .hi_en(hi_en), .ld_act(ld_act), .bus_s(bus_s), .lo_q(lo_q), .hi_q(hi_q),
   .code_o(code_o));

// File: tb/dac_byte_loader_tb_top.sv
module dac_byte_loader_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        auto_xfer = 1'b0;
   logic        lo_sel_n = 1'b1, hi_sel_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1;
   logic [7:0]  bus = 8'h00;
   logic [11:0] code;
   int          checks = 0, errors = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk; // 125 MHz

   dac_byte_loader dut_i (
      .clk(clk), .rst_n(rst_n), .auto_xfer_i(auto_xfer),
      .lo_sel_n_i(lo_sel_n), .hi_sel_n_i(hi_sel_n), .wr_n_i(wr_n),
      .ld_n_i(ld_n), .bus_i(bus), .code_o(code));

   localparam int OP_LO = 0, OP_HI = 1, OP_LD = 2, OP_WR = 3;
   // {auto, op, bus, expected code after the operation}
   localparam logic [22:0] VEC [13] = '{
      {1'b0, 2'd0, 8'h5A, 12'h000},
      {1'b0, 2'd1, 8'hF3, 12'h000},
      {1'b0, 2'd2, 8'h00, 12'h35A},
      {1'b0, 2'd1, 8'h0C, 12'h35A},
      {1'b0, 2'd0, 8'h21, 12'h35A},
      {1'b0, 2'd2, 8'h00, 12'hC21},
      {1'b0, 2'd3, 8'hFF, 12'hC21},
      {1'b1, 2'd0, 8'h77, 12'hC21},
      {1'b1, 2'd1, 8'hA9, 12'h977},
      {1'b1, 2'd1, 8'h41, 12'h177},
      {1'b0, 2'd0, 8'h00, 12'h177},
      {1'b1, 2'd2, 8'h00, 12'h177},
      {1'b0, 2'd2, 8'h00, 12'h100}
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [11:0] exp);
      checks++;
      if (code !== exp) begin
         errors++;
         $display("FAIL %s code=%03h expected=%03h", req, code, exp);
      end
   endtask

   task automatic do_op(input int op, input logic [7:0] d);
      bus = d;
      case (op)
         OP_LO: begin lo_sel_n = 1'b0; wr_n = 1'b0; end
         OP_HI: begin hi_sel_n = 1'b0; wr_n = 1'b0; end
         OP_LD: ld_n = 1'b0;
         default: wr_n = 1'b0;
      endcase
      tick(4);
      lo_sel_n = 1'b1; hi_sel_n = 1'b1; wr_n = 1'b1; ld_n = 1'b1;
      tick(4);
   endtask

   initial begin
      tick(3);
      check("R1 during reset", 12'h000);
      rst_n = 1'b1;
      tick(4);
      check("R1 after reset", 12'h000);

      // vector walk: R2 R3 R5 R6 R7 R8
      for (int i = 0; i < 13; i++) begin
         auto_xfer = VEC[i][22];
         tick(1);
         do_op(int'(VEC[i][21:20]), VEC[i][19:12]);
         check($sformatf("R2/R3/R5/R6/R7/R8 vector %0d", i), VEC[i][11:0]);
      end
      auto_xfer = 1'b0;
      tick(2);

      // R9 latency with DAC stage transparent (also R6)
      ld_n = 1'b0;
      tick(4);
      bus = 8'hE7; lo_sel_n = 1'b0; wr_n = 1'b0;
      tick(2);
      check("R9 not before SYNC_STAGES+1 edges", 12'h100);
      tick(1);
      check("R9 visible at SYNC_STAGES+1 edges", 12'h1E7);
      lo_sel_n = 1'b1; wr_n = 1'b1;
      tick(4);
      ld_n = 1'b1;
      tick(4);

      // R4 lock on select edge while write stays low
      bus = 8'h11; lo_sel_n = 1'b0; wr_n = 1'b0;
      tick(4);
      lo_sel_n = 1'b1; bus = 8'h99;
      tick(4);
      wr_n = 1'b1;
      tick(4);
      // R4 lock on write edge while select stays low
      bus = 8'h05; hi_sel_n = 1'b0; wr_n = 1'b0;
      tick(4);
      wr_n = 1'b1; bus = 8'h0E;
      tick(4);
      hi_sel_n = 1'b1;
      tick(4);
      check("R6 hold without load", 12'h1E7);
      do_op(OP_LD, 8'h00);
      check("R4 select/write edge lock", 12'h511);

      // R8 bus activity with no select, load held low
      ld_n = 1'b0;
      for (int k = 0; k < 6; k++) begin
         bus = 8'(k * 37);
         wr_n = k[0];
         tick(1);
      end
      wr_n = 1'b1;
      tick(4);
      check("R8 no select no transfer", 12'h511);
      ld_n = 1'b1;
      tick(2);

      // R7 automatic transfer in low-then-high order with ld_n ignored
      auto_xfer = 1'b1;
      tick(1);
      do_op(OP_LO, 8'h3C);
      check("R7 low write alone holds", 12'h511);
      do_op(OP_HI, 8'h0B);
      check("R7 high write transfers", 12'hB3C);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired code=%03h expected=done", code);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule